// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

The block gathers interrupt requests for a small processor core and decides which one the core should service next. Peripheral sources arrive as pairs of a status flag and an enable bit. Each pair maps onto an interrupt number, and several pairs may share one number. Three further sources enter as one-cycle strobes: a software trap, an illegal-opcode trap and a non-maskable line. All of them are kept in a pending mask that is refreshed on every clock.

Selection follows a fixed order. The two traps come first. The non-maskable line comes next and is gated by the core's X mask. The remaining maskable numbers are gated by the core's I mask and are ranked by a writable priority table. When a choice exists and the block is idle, it presents the interrupt number and its vector fetch address, and holds both until the core acknowledges. On acknowledge it pulses the mask bit the core must set. It then stays busy for the entry overhead before it offers anything new.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending bit of a peripheral-driven interrupt number follows the OR of (flag AND enable) over its pairs, with one clock of delay. When no pair is active, the bit is clear after that edge, and an interrupt whose cause disappears before it is offered is never offered.
- R2: Pairs 0 to 3 share interrupt number 2. While any one of them has flag and enable both 1, number 2 stays pending, even when another of those causes is cleared on the same cycle.
- R3: The software trap (number 13) outranks every other source. The illegal-opcode trap (number 14) comes next. Both are taken whatever the I and X masks are, and taking one clears only its own pending bit.
- R4: A pending non-maskable request (number 12) is offered only when X is 0, and acknowledging it clears its pending bit. While it is pending with X at 1, nothing is offered, even if maskable sources are pending and I is 0.
- R5: When I is 1, no maskable source is offered.
- R6: Maskable numbers are ranked by a priority table of N_ID slots, and the pending number in the lowest slot wins. After reset, slot k holds number k. A write with prio_we stores prio_val into slot prio_slot at the next edge.
- R7: Taking a maskable interrupt leaves its pending bit set. If the cause is still active, the same number is offered again once the entry overhead has ended.
- R8: vec_addr equals base + 2 × irq_id, where base is 0xFFC0 with special_mode at 0 and 0xBFC0 with special_mode at 1.
- R9: In the cycle after an acknowledge, set_x pulses for number 12 and set_i pulses for any other number. The pulse lasts exactly one cycle.
- R10: irq_valid, irq_id and vec_addr stay stable until ack. After an acknowledge, entry_busy is high for exactly 14 cycles (ENTRY_CYC), and irq_valid is low during that time.
- R11: Reset clears the pending mask and all outputs, including a trap that was pending but had not yet been offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_flag | input | N_SRC | Peripheral status flags, one per pair |
| src_en | input | N_SRC | Peripheral enable bits, one per pair |
| swi_req | input | 1 | Software trap strobe |
| ill_req | input | 1 | Illegal-opcode trap strobe |
| xirq_req | input | 1 | Non-maskable request strobe |
| ccr_i | input | 1 | Core I mask bit |
| ccr_x | input | 1 | Core X mask bit |
| special_mode | input | 1 | Selects the bootstrap vector base |
| prio_we | input | 1 | Priority table write enable |
| prio_slot | input | ID_W | Priority table slot to write |
| prio_val | input | ID_W | Interrupt number stored into the slot |
| ack | input | 1 | Core accepts the offered interrupt |
| irq_valid | output | 1 | An interrupt is being offered |
| irq_id | output | ID_W | Offered interrupt number |
| vec_addr | output | VEC_W | Vector fetch address |
| set_i | output | 1 | One-cycle request to set the I mask |
| set_x | output | 1 | One-cycle request to set the X mask |
| entry_busy | output | 1 | Entry overhead in progress |

## Verification
A request presented before an edge reaches the pending mask on that edge, and it is offered on irq_valid, irq_id and vec_addr one edge later. The bench therefore samples on the falling edge two cycles after it drives. The mask pulse is due on the first edge after the acknowledge, so it is read on the following falling edge. entry_busy is counted falling edge by falling edge until it drops. A re-offer is expected one cycle after the block returns to idle, and the bench samples there. Every table row starts from a fresh reset, so pending state left by an earlier row cannot mask an error.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_OFFER = 2'd1,
    SEQ_ENTRY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N_ID    = 16,
  parameter int N_SRC   = 8,
  parameter int ID_W    = 4,
  parameter int SRC_MAP [N_SRC] = '{2, 2, 2, 2, 3, 5, 7, 9},
  parameter int SWI_ID  = 13,
  parameter int ILL_ID  = 14,
  parameter int XIRQ_ID = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] src_en,
  input  logic             swi_req,
  input  logic             ill_req,
  input  logic             xirq_req,
  input  logic             take,
  input  logic [ID_W-1:0]  take_id,
  output logic [N_ID-1:0]  pend_q
);
  localparam int N_TRAP = 3;
  localparam int TRAP_ID [N_TRAP] = '{SWI_ID, ILL_ID, XIRQ_ID};

  logic [N_ID-1:0]   cause;
  logic [N_ID-1:0]   pend_d;
  logic [N_TRAP-1:0] trap_req;
  logic [N_TRAP-1:0] trap_next;

  assign trap_req = {xirq_req, ill_req, swi_req};

  // Shared numbers: OR of all active causes (all clears, then all sets).
  always_comb begin
    cause = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src_flag[s] && src_en[s]) cause[SRC_MAP[s]] = 1'b1;
    end
  end

  // Strobe-driven sources latch until taken; a new strobe wins over the clear.
  for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
    assign trap_next[t] = (pend_q[TRAP_ID[t]] &&
                           !(take && take_id == ID_W'(TRAP_ID[t]))) || trap_req[t];
  end

  always_comb begin
    pend_d = cause;
    for (int t = 0; t < N_TRAP; t++) pend_d[TRAP_ID[t]] = trap_next[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R1: a cause seen at an edge shows as pending right after it
  p_cause_seen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_flag[0] && src_en[0]) |=> pend_q[SRC_MAP[0]]);
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int N_ID    = 16,
  parameter int ID_W    = 4,
  parameter int SWI_ID  = 13,
  parameter int ILL_ID  = 14,
  parameter int XIRQ_ID = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_ID-1:0] pend,
  input  logic            ccr_i,
  input  logic            ccr_x,
  input  logic            prio_we,
  input  logic [ID_W-1:0] prio_slot,
  input  logic [ID_W-1:0] prio_val,
  output logic            sel_valid,
  output logic [ID_W-1:0] sel_id
);
  logic [ID_W-1:0] order_q [N_ID];
  logic [ID_W-1:0] order_d [N_ID];
  logic            walk_valid;
  logic [ID_W-1:0] walk_id;

  function automatic logic maskable(input logic [ID_W-1:0] id);
    return id != ID_W'(SWI_ID) && id != ID_W'(ILL_ID) && id != ID_W'(XIRQ_ID);
  endfunction

  always_comb begin
    for (int k = 0; k < N_ID; k++) order_d[k] = order_q[k];
    if (prio_we) order_d[prio_slot] = prio_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_ID; k++) order_q[k] <= ID_W'(k);
    end else if (prio_we) begin
      for (int k = 0; k < N_ID; k++) order_q[k] <= order_d[k];
    end
  end

  // Lowest slot holding a pending maskable number wins.
  always_comb begin
    walk_valid = 1'b0;
    walk_id    = '0;
    for (int s = N_ID - 1; s >= 0; s--) begin
      if (pend[order_q[s]] && maskable(order_q[s])) begin
        walk_valid = 1'b1;
        walk_id    = order_q[s];
      end
    end
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    if (pend[SWI_ID]) begin
      sel_valid = 1'b1;
      sel_id    = ID_W'(SWI_ID);
    end else if (pend[ILL_ID]) begin
      sel_valid = 1'b1;
      sel_id    = ID_W'(ILL_ID);
    end else if (pend[XIRQ_ID]) begin
      sel_valid = !ccr_x;
      sel_id    = ID_W'(XIRQ_ID);
    end else if (!ccr_i) begin
      sel_valid = walk_valid;
      sel_id    = walk_id;
    end
  end

  p_xirq_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[XIRQ_ID] && ccr_x && !pend[SWI_ID] && !pend[ILL_ID]) |-> !sel_valid);
  p_imask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_i && !pend[SWI_ID] && !pend[ILL_ID] && !pend[XIRQ_ID]) |-> !sel_valid);
  p_trap_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend[SWI_ID] |-> (sel_valid && sel_id == ID_W'(SWI_ID)));
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
#(
  parameter int          ID_W         = 4,
  parameter int          VEC_W        = 16,
  parameter int          XIRQ_ID      = 12,
  parameter int          ENTRY_CYC    = 14,
  parameter logic [15:0] BASE_NORMAL  = 16'hFFC0,
  parameter logic [15:0] BASE_SPECIAL = 16'hBFC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_valid,
  input  logic [ID_W-1:0]  sel_id,
  input  logic             ack,
  input  logic             special_mode,
  output logic             irq_valid,
  output logic [ID_W-1:0]  irq_id,
  output logic [VEC_W-1:0] vec_addr,
  output logic             set_i,
  output logic             set_x,
  output logic             entry_busy,
  output logic             take
);
  localparam int CNT_W = $clog2(ENTRY_CYC + 1);

  seq_state_e       state_q, state_d;
  logic [ID_W-1:0]  id_q;
  logic             id_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seti_d, setx_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    id_en   = 1'b0;
    take    = 1'b0;
    seti_d  = 1'b0;
    setx_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: if (sel_valid) begin
        state_d = SEQ_OFFER;
        id_en   = 1'b1;
      end
      SEQ_OFFER: if (ack) begin
        take    = 1'b1;
        state_d = SEQ_ENTRY;
        cnt_d   = CNT_W'(ENTRY_CYC - 1);
        if (id_q == ID_W'(XIRQ_ID)) setx_d = 1'b1;
        else                        seti_d = 1'b1;
      end
      SEQ_ENTRY: begin
        if (cnt_q == '0) state_d = SEQ_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      id_q    <= '0;
      set_i   <= 1'b0;
      set_x   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      set_i   <= seti_d;
      set_x   <= setx_d;
      if (id_en) id_q <= sel_id;
    end
  end

  assign irq_valid  = (state_q == SEQ_OFFER);
  assign entry_busy = (state_q == SEQ_ENTRY);
  assign irq_id     = id_q;
  assign vec_addr   = (special_mode ? VEC_W'(BASE_SPECIAL) : VEC_W'(BASE_NORMAL))
                      + VEC_W'({id_q, 1'b0});

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_id)));
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    entry_busy |-> !irq_valid);
  p_mask_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack) |=> ($countones({set_i, set_x}) == 1));
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i || set_x) |=> !(set_i || set_x));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int          N_ID         = 16,
  parameter int          ID_W         = $clog2(N_ID),
  parameter int          N_SRC        = 8,
  parameter int          SRC_MAP [N_SRC] = '{2, 2, 2, 2, 3, 5, 7, 9},
  parameter int          SWI_ID       = 13,
  parameter int          ILL_ID       = 14,
  parameter int          XIRQ_ID      = 12,
  parameter int          VEC_W        = 16,
  parameter int          ENTRY_CYC    = 14,
  parameter logic [15:0] BASE_NORMAL  = 16'hFFC0,
  parameter logic [15:0] BASE_SPECIAL = 16'hBFC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] src_en,
  input  logic             swi_req,
  input  logic             ill_req,
  input  logic             xirq_req,
  input  logic             ccr_i,
  input  logic             ccr_x,
  input  logic             special_mode,
  input  logic             prio_we,
  input  logic [ID_W-1:0]  prio_slot,
  input  logic [ID_W-1:0]  prio_val,
  input  logic             ack,
  output logic             irq_valid,
  output logic [ID_W-1:0]  irq_id,
  output logic [VEC_W-1:0] vec_addr,
  output logic             set_i,
  output logic             set_x,
  output logic             entry_busy
);
  // rst_n is asserted asynchronously and is expected to be deasserted
  // in step with clk by the reset tree.
  logic [N_ID-1:0] pend;
  logic            sel_valid;
  logic [ID_W-1:0] sel_id;
  logic            take;

  irqc_pending #(
    .N_ID(N_ID), .N_SRC(N_SRC), .ID_W(ID_W), .SRC_MAP(SRC_MAP),
    .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .swi_req(swi_req), .ill_req(ill_req), .xirq_req(xirq_req),
    .take(take), .take_id(irq_id), .pend_q(pend)
  );

  irqc_select #(
    .N_ID(N_ID), .ID_W(ID_W), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ccr_i(ccr_i), .ccr_x(ccr_x),
    .prio_we(prio_we), .prio_slot(prio_slot), .prio_val(prio_val),
    .sel_valid(sel_valid), .sel_id(sel_id)
  );

  irqc_seq #(
    .ID_W(ID_W), .VEC_W(VEC_W), .XIRQ_ID(XIRQ_ID), .ENTRY_CYC(ENTRY_CYC),
    .BASE_NORMAL(BASE_NORMAL), .BASE_SPECIAL(BASE_SPECIAL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_id(sel_id),
    .ack(ack), .special_mode(special_mode), .irq_valid(irq_valid),
    .irq_id(irq_id), .vec_addr(vec_addr), .set_i(set_i), .set_x(set_x),
    .entry_busy(entry_busy), .take(take)
  );

  p_trap_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack && irq_id == ID_W'(SWI_ID) && !swi_req) |=> !pend[SWI_ID]);
  p_xirq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack && irq_id == ID_W'(XIRQ_ID) && !xirq_req) |=> !pend[XIRQ_ID]);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] src_flag, src_en;
  logic       swi_req, ill_req, xirq_req, ccr_i, ccr_x, special_mode;
  logic       prio_we, ack;
  logic [3:0] prio_slot, prio_val;
  logic       irq_valid, set_i, set_x, entry_busy;
  logic [3:0] irq_id;
  logic [15:0] vec_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .swi_req(swi_req), .ill_req(ill_req), .xirq_req(xirq_req),
    .ccr_i(ccr_i), .ccr_x(ccr_x), .special_mode(special_mode),
    .prio_we(prio_we), .prio_slot(prio_slot), .prio_val(prio_val), .ack(ack),
    .irq_valid(irq_valid), .irq_id(irq_id), .vec_addr(vec_addr),
    .set_i(set_i), .set_x(set_x), .entry_busy(entry_busy)
  );

  // flag, en, swi, ill, xirq, ccr_i, ccr_x, special, exp_valid, exp_id
  localparam int NROW = 11;
  localparam logic [26:0] ROWS [NROW] = '{
    {8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R1
    {8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0},  // R1
    {8'h08, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
    {8'h81, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R6
    {8'h80, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R5
    {8'h01, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd13}, // R3
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd14}, // R3
    {8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd12}, // R4
    {8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},  // R4
    {8'h10, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // R8
    {8'h40, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic sp, input logic [3:0] id);
    return (sp ? 16'hBFC0 : 16'hFFC0) + 16'(id) * 16'd2;
  endfunction

  task automatic clear_inputs();
    src_flag = '0; src_en = '0; swi_req = 0; ill_req = 0; xirq_req = 0;
    ccr_i = 0; ccr_x = 0; special_mode = 0; prio_we = 0; prio_slot = '0;
    prio_val = '0; ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // Counts busy cycles at falling edges; flags any offer seen while busy.
  task automatic wait_busy(output int n, output int offers);
    n = 0; offers = 0;
    while (entry_busy) begin
      n++;
      if (irq_valid) offers++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int nb, no;
    clear_inputs();
    rst_n = 0;
    @(negedge clk);

    // R11: reset state, and a trap pending before reset is forgotten
    do_reset();
    chk("R11 valid", irq_valid, 0);
    chk("R11 busy", entry_busy, 0);
    chk("R11 set", {set_i, set_x}, 0);
    swi_req = 1;
    @(negedge clk);
    swi_req = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R11 pending cleared", irq_valid, 0);

    // Table walk
    for (int r = 0; r < NROW; r++) begin
      logic [26:0] v;
      v = ROWS[r];
      do_reset();
      src_flag = v[26:19]; src_en = v[18:11];
      swi_req = v[10]; ill_req = v[9]; xirq_req = v[8];
      ccr_i = v[7]; ccr_x = v[6]; special_mode = v[5];
      @(negedge clk);
      swi_req = 0; ill_req = 0; xirq_req = 0;
      @(negedge clk);
      chk($sformatf("R%0d row%0d valid", (r < 2) ? 1 : 3, r), irq_valid, v[4]);
      if (v[4]) begin
        chk($sformatf("R6 row%0d id", r), irq_id, v[3:0]);
        chk($sformatf("R8 row%0d vector", r), vec_addr, exp_vec(v[5], v[3:0]));
        ack = 1; src_flag = '0; src_en = '0;
        @(negedge clk);
        ack = 0;
        chk($sformatf("R9 row%0d set_i", r), set_i, (v[3:0] != 4'd12));
        chk($sformatf("R9 row%0d set_x", r), set_x, (v[3:0] == 4'd12));
      end
    end

    // R10 hold, R3 precedence after entry, R7 re-fire
    do_reset();
    src_flag = 8'h01; src_en = 8'h01;
    repeat (2) @(negedge clk);
    chk("R1 offer id2", irq_id, 2);
    swi_req = 1;
    @(negedge clk);
    swi_req = 0;
    @(negedge clk);
    chk("R10 still valid", irq_valid, 1);
    chk("R10 id held", irq_id, 2);
    ack = 1;
    @(negedge clk);
    ack = 0;
    chk("R9 set_i maskable", set_i, 1);
    @(negedge clk);
    chk("R9 single pulse", set_i, 0);
    wait_busy(nb, no);
    chk("R10 busy length", nb + 1, 14);
    chk("R10 no offer while busy", no, 0);
    @(negedge clk);
    chk("R3 swi first", irq_id, 13);
    chk("R3 swi valid", irq_valid, 1);
    ack = 1;
    @(negedge clk);
    ack = 0;
    wait_busy(nb, no);
    @(negedge clk);
    chk("R7 re-fire valid", irq_valid, 1);
    chk("R7 re-fire id (R3 swi cleared)", irq_id, 2);

    // R2 shared number survives clearing one cause; R1 clear after all gone
    do_reset();
    src_flag = 8'h03; src_en = 8'h03;
    repeat (2) @(negedge clk);
    chk("R2 offer id2", irq_id, 2);
    ack = 1; src_flag = 8'h02;
    @(negedge clk);
    ack = 0;
    wait_busy(nb, no);
    @(negedge clk);
    chk("R2 shared still pending", irq_valid, 1);
    ack = 1; src_flag = 8'h00;
    @(negedge clk);
    ack = 0;
    wait_busy(nb, no);
    @(negedge clk);
    chk("R1 cleared when causes gone", irq_valid, 0);

    // R6 priority table write
    do_reset();
    prio_we = 1; prio_slot = 4'd0; prio_val = 4'd9;
    @(negedge clk);
    prio_we = 0;
    src_flag = 8'h81; src_en = 8'h81;
    repeat (2) @(negedge clk);
    chk("R6 rewritten order id", irq_id, 9);
    chk("R8 vector id9", vec_addr, 16'hFFD2);

    // R1 cause withdrawn before it could be offered
    do_reset();
    ccr_i = 1; src_flag = 8'h01; src_en = 8'h01;
    @(negedge clk);
    src_en = 8'h00;
    @(negedge clk);
    ccr_i = 0;
    repeat (2) @(negedge clk);
    chk("R1 withdrawn cause", irq_valid, 0);

    // R4 blocked then released
    do_reset();
    ccr_x = 1; src_flag = 8'h01; src_en = 8'h01; xirq_req = 1;
    @(negedge clk);
    xirq_req = 0;
    repeat (3) @(negedge clk);
    chk("R4 blocked", irq_valid, 0);
    ccr_x = 0;
    @(negedge clk);
    chk("R4 unblocked id", irq_id, 12);
    chk("R8 vector xirq", vec_addr, 16'hFFD8);
    ack = 1; src_flag = 8'h00;
    @(negedge clk);
    ack = 0;
    chk("R9 set_x", set_x, 1);
    chk("R9 no set_i", set_i, 0);
    wait_busy(nb, no);
    @(negedge clk);
    chk("R4 xirq cleared", irq_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule